// File: doc/BRIEF.md
# I2C Controller Event Status, Interrupt and DMA Request Unit

This unit holds the event status of an I2C controller together with its interrupt enable mask. It drives a single interrupt line plus two DMA request lines, one for the receive direction and one for the transmit direction. The transfer sequencer records events by pulsing per-bit set and clear strobes. Software reads and writes five small registers through a simple request port.

A parameter selects one of two register behaviours. In the legacy behaviour, the status register cannot be written. Software retires events by reading a vector register, which returns the number of the lowest pending enabled event and clears that event. In the current behaviour, software clears selected events by writing ones to the status register. A test register can also force the low six events high.

Register selector values on `req_addr_i` are 0 = enable mask, 1 = status, 2 = vector, 3 = DMA configuration, 4 = test (write only, reads 0). Read data and `rd_valid_o` are registered. They appear on the clock edge that accepts the read. Any state change caused by that read takes effect at the same edge.

Top module: `i2c_irq_dma_ctrl`

## Requirements
- R1: `irq_o` is high exactly when the status register AND the enable mask is nonzero, one clock after that register state.
- R2: `dreq_rx_o` follows status bit 3 while DMA configuration bit 15 is set. `dreq_tx_o` follows status bit 4 while configuration bit 7 is set. Both are registered one clock behind, and both are low while their enable is clear.
- R3: A DMA configuration write stores only bits 15 and 7. Writing bit 15 as one clears mask bit 3, and writing bit 7 as one clears mask bit 4.
- R4: The enable mask keeps 5 bits (bits 4..0) in legacy mode and 6 bits (bits 5..0) in current mode. Higher written bits read back as zero.
- R5: In legacy mode, a vector read returns the one-based index of the lowest set bit of status AND mask, or 0 if none is set, and clears that status bit.
- R6: In current mode, a status write clears those of bits 0, 1, 2 and 5 that are written as one. Bits 3, 4 and all others are unaffected; they clear only by strobe.
- R7: In legacy mode, a status write changes nothing. In current mode, a vector read returns 0 and changes nothing.
- R8: A status read reports the `bus_busy_i` input in bit 12. Bit 12 is never stored.
- R9: In current mode, a test register write with bit 11 set forces status bits 5..0 to one. In legacy mode it has no effect.
- R10: When a set strobe and a clear strobe hit the same status bit in one cycle, the bit ends up set.
- R11: After reset, all registers are zero and `irq_o`, `dreq_rx_o`, `dreq_tx_o` and `rd_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 3 | Register selector |
| req_wdata_i | input | 16 | Write data |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 16 | Read data |
| evt_set_i | input | 16 | Per-bit status set strobes |
| evt_clr_i | input | 16 | Per-bit status clear strobes |
| bus_busy_i | input | 1 | Bus busy indication, reported in status bit 12 |
| irq_o | output | 1 | Interrupt request |
| dreq_rx_o | output | 1 | Receive DMA request |
| dreq_tx_o | output | 1 | Transmit DMA request |

## Verification
The assertions check several properties on every cycle. The interrupt line always tracks the masked status one clock later. A disabled DMA direction never raises its request. A same-cycle set and clear always leaves the bit set. The ready bits survive anything but their own clear strobe, and a legacy status write leaves the register untouched. Other behaviours need the bench's directed scenarios: the read-back widths of the mask, the exact vector numbering and the one-bit retirement sequence, the write-one-to-clear bit selection, the forced pattern from the test register, and the busy bit in read data.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_MASK = 3'd0,
    REG_STAT = 3'd1,
    REG_VECT = 3'd2,
    REG_DMA  = 3'd3,
    REG_TEST = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/i2c_evt_status.sv
module i2c_evt_status #(
  parameter int          DATA_W      = 16,
  parameter bit          LEGACY      = 1'b0,
  parameter int          BUSY_BIT    = 12,
  parameter int          FORCE_CNT   = 6,
  parameter logic [15:0] SW_CLR_MASK = 16'h0027,
  parameter int          RX_RDY_BIT  = 3,
  parameter int          TX_RDY_BIT  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] evt_set_i,
  input  logic [DATA_W-1:0] evt_clr_i,
  input  logic              sw_clr_we_i,
  input  logic [DATA_W-1:0] sw_clr_data_i,
  input  logic              force_we_i,
  input  logic [DATA_W-1:0] vec_clr_i,
  output logic [DATA_W-1:0] stat_o
);
  localparam logic [DATA_W-1:0] STORE_MASK = ~(DATA_W'(1) << BUSY_BIT);
  localparam logic [DATA_W-1:0] FORCE_MASK = (DATA_W'(1) << FORCE_CNT) - DATA_W'(1);
  localparam logic [DATA_W-1:0] W1C_MASK   = DATA_W'(SW_CLR_MASK);

  logic [DATA_W-1:0] stat_q, stat_d, clr_vec, set_vec;

  generate
    if (LEGACY) begin : g_legacy
      // status register is read-only; vector reads retire events
      always_comb begin
        clr_vec = evt_clr_i | vec_clr_i;
        set_vec = evt_set_i;
      end
    end else begin : g_current
      always_comb begin
        clr_vec = evt_clr_i | vec_clr_i;
        if (sw_clr_we_i) clr_vec = clr_vec | (sw_clr_data_i & W1C_MASK);
        set_vec = evt_set_i;
        if (force_we_i) set_vec = set_vec | FORCE_MASK;
      end
    end
  endgenerate

  // set wins over clear
  assign stat_d = ((stat_q & ~clr_vec) | set_vec) & STORE_MASK;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|(evt_set_i & STORE_MASK)) |=>
      ((stat_q & $past(evt_set_i & STORE_MASK)) == $past(evt_set_i & STORE_MASK))); // R10

  AST_RX_RDY_STICKY: assert property (@(posedge clk) disable iff (rst)
    (stat_q[RX_RDY_BIT] && !evt_clr_i[RX_RDY_BIT] && !vec_clr_i[RX_RDY_BIT]) |=>
      stat_q[RX_RDY_BIT]); // R6

  AST_TX_RDY_STICKY: assert property (@(posedge clk) disable iff (rst)
    (stat_q[TX_RDY_BIT] && !evt_clr_i[TX_RDY_BIT] && !vec_clr_i[TX_RDY_BIT]) |=>
      stat_q[TX_RDY_BIT]); // R6

  AST_LEGACY_STAT_RO: assert property (@(posedge clk) disable iff (rst)
    (LEGACY && sw_clr_we_i && evt_set_i == '0 && evt_clr_i == '0 &&
     vec_clr_i == '0 && !force_we_i) |=> $stable(stat_q)); // R7

  AST_BUSY_NOT_STORED: assert property (@(posedge clk) disable iff (rst)
    !stat_q[BUSY_BIT]); // R8
endmodule

// File: rtl/i2c_mask_cfg.sv
module i2c_mask_cfg #(
  parameter int DATA_W     = 16,
  parameter int MASK_W     = 6,
  parameter int RX_RDY_BIT = 3,
  parameter int TX_RDY_BIT = 4,
  parameter int RX_DMA_BIT = 15,
  parameter int TX_DMA_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mask_we_i,
  input  logic              dma_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] dma_o
);
  localparam logic [DATA_W-1:0] MASK_KEEP = (DATA_W'(1) << MASK_W) - DATA_W'(1);
  localparam logic [DATA_W-1:0] DMA_KEEP  = (DATA_W'(1) << RX_DMA_BIT) | (DATA_W'(1) << TX_DMA_BIT);

  logic [DATA_W-1:0] mask_q, dma_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      dma_q  <= '0;
    end else if (mask_we_i) begin
      mask_q <= wdata_i & MASK_KEEP;
    end else if (dma_we_i) begin
      dma_q <= wdata_i & DMA_KEEP;
      if (wdata_i[RX_DMA_BIT]) mask_q[RX_RDY_BIT] <= 1'b0;
      if (wdata_i[TX_DMA_BIT]) mask_q[TX_RDY_BIT] <= 1'b0;
    end
  end

  assign mask_o = mask_q;
  assign dma_o  = dma_q;

  AST_RX_DMA_DROPS_IE: assert property (@(posedge clk) disable iff (rst)
    (dma_we_i && !mask_we_i && wdata_i[RX_DMA_BIT]) |=> !mask_q[RX_RDY_BIT]); // R3

  AST_TX_DMA_DROPS_IE: assert property (@(posedge clk) disable iff (rst)
    (dma_we_i && !mask_we_i && wdata_i[TX_DMA_BIT]) |=> !mask_q[TX_RDY_BIT]); // R3
endmodule

// File: rtl/i2c_irq_vector.sv
module i2c_irq_vector #(
  parameter int DATA_W = 16,
  parameter int VEC_W  = 5
) (
  input  logic [DATA_W-1:0] pending_i,
  output logic [VEC_W-1:0]  index_o,
  output logic [DATA_W-1:0] first_o
);
  logic [DATA_W-1:0] below;

  generate
    for (genvar g = 0; g < DATA_W; g++) begin : g_chain
      if (g == 0) begin : g_lsb
        assign below[g] = 1'b0;
      end else begin : g_upper
        assign below[g] = below[g-1] | pending_i[g-1];
      end
      assign first_o[g] = pending_i[g] & ~below[g];
    end
  endgenerate

  always_comb begin
    index_o = '0;
    for (int g = 0; g < DATA_W; g++) begin
      if (first_o[g]) index_o = index_o | VEC_W'(g + 1);
    end
  end

  always_comb begin
    assert ($onehot0(first_o)); // R5
  end
endmodule

// File: rtl/i2c_req_out.sv
module i2c_req_out #(
  parameter int DATA_W     = 16,
  parameter int RX_RDY_BIT = 3,
  parameter int TX_RDY_BIT = 4,
  parameter int RX_DMA_BIT = 15,
  parameter int TX_DMA_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] stat_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] dma_i,
  output logic              irq_o,
  output logic              dreq_rx_o,
  output logic              dreq_tx_o
);
  logic irq_q, rx_q, tx_q;
  logic pending_any;

  assign pending_any = |(stat_i & mask_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      rx_q  <= 1'b0;
      tx_q  <= 1'b0;
    end else begin
      irq_q <= pending_any;
      rx_q  <= stat_i[RX_RDY_BIT] & dma_i[RX_DMA_BIT];
      tx_q  <= stat_i[TX_RDY_BIT] & dma_i[TX_DMA_BIT];
    end
  end

  assign irq_o     = irq_q;
  assign dreq_rx_o = rx_q;
  assign dreq_tx_o = tx_q;

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(|(stat_i & mask_i)))); // R1

  AST_RX_DREQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !dma_i[RX_DMA_BIT] |=> !dreq_rx_o); // R2

  AST_TX_DREQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !dma_i[TX_DMA_BIT] |=> !dreq_tx_o); // R2
endmodule

// File: rtl/i2c_irq_dma_ctrl.sv
module i2c_irq_dma_ctrl
  import i2c_irq_pkg::*;
#(
  parameter int          DATA_W      = 16,
  parameter bit          LEGACY      = 1'b0,
  parameter int          RX_RDY_BIT  = 3,
  parameter int          TX_RDY_BIT  = 4,
  parameter int          RX_DMA_BIT  = 15,
  parameter int          TX_DMA_BIT  = 7,
  parameter int          BUSY_BIT    = 12,
  parameter int          FORCE_BIT   = 11,
  parameter int          FORCE_CNT   = 6,
  parameter logic [15:0] SW_CLR_MASK = 16'h0027,
  parameter int          MASK_W_OLD  = 5,
  parameter int          MASK_W_NEW  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [REG_AW-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [DATA_W-1:0] evt_set_i,
  input  logic [DATA_W-1:0] evt_clr_i,
  input  logic              bus_busy_i,
  output logic              irq_o,
  output logic              dreq_rx_o,
  output logic              dreq_tx_o
);
  localparam int MASK_W = LEGACY ? MASK_W_OLD : MASK_W_NEW;
  localparam int VEC_W  = $clog2(DATA_W + 1);

  logic              wr_en, rd_en;
  logic              mask_we, dma_we, stat_we, test_we, vec_rd;
  logic [DATA_W-1:0] stat, mask, dma, vec_first, vec_clr, rd_mux;
  logic [VEC_W-1:0]  vec_idx;
  logic              rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;

  assign wr_en   = req_valid_i &  req_write_i;
  assign rd_en   = req_valid_i & ~req_write_i;
  assign mask_we = wr_en && req_addr_i == REG_MASK;
  assign dma_we  = wr_en && req_addr_i == REG_DMA;
  assign stat_we = wr_en && req_addr_i == REG_STAT;
  assign test_we = wr_en && req_addr_i == REG_TEST;
  assign vec_rd  = rd_en && req_addr_i == REG_VECT;

  i2c_mask_cfg #(
    .DATA_W(DATA_W), .MASK_W(MASK_W),
    .RX_RDY_BIT(RX_RDY_BIT), .TX_RDY_BIT(TX_RDY_BIT),
    .RX_DMA_BIT(RX_DMA_BIT), .TX_DMA_BIT(TX_DMA_BIT)
  ) u_cfg (
    .clk(clk), .rst(rst),
    .mask_we_i(mask_we), .dma_we_i(dma_we), .wdata_i(req_wdata_i),
    .mask_o(mask), .dma_o(dma)
  );

  i2c_irq_vector #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_vec (
    .pending_i(stat & mask), .index_o(vec_idx), .first_o(vec_first)
  );

  assign vec_clr = (LEGACY && vec_rd) ? vec_first : '0;

  i2c_evt_status #(
    .DATA_W(DATA_W), .LEGACY(LEGACY), .BUSY_BIT(BUSY_BIT),
    .FORCE_CNT(FORCE_CNT), .SW_CLR_MASK(SW_CLR_MASK),
    .RX_RDY_BIT(RX_RDY_BIT), .TX_RDY_BIT(TX_RDY_BIT)
  ) u_stat (
    .clk(clk), .rst(rst),
    .evt_set_i(evt_set_i), .evt_clr_i(evt_clr_i),
    .sw_clr_we_i(stat_we), .sw_clr_data_i(req_wdata_i),
    .force_we_i(test_we && req_wdata_i[FORCE_BIT]),
    .vec_clr_i(vec_clr), .stat_o(stat)
  );

  i2c_req_out #(
    .DATA_W(DATA_W),
    .RX_RDY_BIT(RX_RDY_BIT), .TX_RDY_BIT(TX_RDY_BIT),
    .RX_DMA_BIT(RX_DMA_BIT), .TX_DMA_BIT(TX_DMA_BIT)
  ) u_out (
    .clk(clk), .rst(rst),
    .stat_i(stat), .mask_i(mask), .dma_i(dma),
    .irq_o(irq_o), .dreq_rx_o(dreq_rx_o), .dreq_tx_o(dreq_tx_o)
  );

  always_comb begin
    rd_mux = '0;
    case (req_addr_i)
      REG_MASK: rd_mux = mask;
      REG_STAT: rd_mux = stat | (DATA_W'(bus_busy_i) << BUSY_BIT);
      REG_VECT: rd_mux = LEGACY ? DATA_W'(vec_idx) : '0;
      REG_DMA:  rd_mux = dma;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) rd_data_q <= rd_mux;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;

  AST_CURRENT_VEC_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!LEGACY && vec_rd) |=> (rd_data_o == '0)); // R7
endmodule

// File: tb/i2c_irq_dma_ctrl_tb.sv
module i2c_irq_dma_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [15:0] req_wdata = '0, evt_set = '0, evt_clr = '0;
  logic        bus_busy = 1'b0;

  logic        n_rv, n_irq, n_rx, n_tx;
  logic [15:0] n_rd;
  logic        o_rv, o_irq, o_rx, o_tx;
  logic [15:0] o_rd;
  logic [15:0] rd_new, rd_old;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_irq_dma_ctrl #(.LEGACY(1'b0)) dut_i (
    .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rd_valid_o(n_rv),
    .rd_data_o(n_rd), .evt_set_i(evt_set), .evt_clr_i(evt_clr),
    .bus_busy_i(bus_busy), .irq_o(n_irq), .dreq_rx_o(n_rx), .dreq_tx_o(n_tx)
  );

  i2c_irq_dma_ctrl #(.LEGACY(1'b1)) dut_old_i (
    .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rd_valid_o(o_rv),
    .rd_data_o(o_rd), .evt_set_i(evt_set), .evt_clr_i(evt_clr),
    .bus_busy_i(bus_busy), .irq_o(o_irq), .dreq_rx_o(o_rx), .dreq_tx_o(o_tx)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; evt_set = '0; evt_clr = '0; bus_busy = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    rd_new = n_rd; rd_old = o_rd;
  endtask

  task automatic pulse(input logic [15:0] s, input logic [15:0] c);
    @(negedge clk);
    evt_set = s; evt_clr = c;
    @(negedge clk);
    evt_set = '0; evt_clr = '0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R11 irq", {15'b0, n_irq | o_irq}, 16'h0);
    check("R11 dreq", {14'b0, n_rx | o_rx, n_tx | o_tx}, 16'h0);
    check("R11 rd_valid", {15'b0, n_rv | o_rv}, 16'h0);
    reg_rd(3'd0);
    check("R11 mask", rd_new | rd_old, 16'h0);
    check("R11 rd_valid high", {15'b0, n_rv & o_rv}, 16'h1);
    reg_rd(3'd1);
    check("R11 status", rd_new | rd_old, 16'h0);
  endtask

  task automatic t_mask_width();
    do_reset();
    reg_wr(3'd0, 16'hFFFF);
    reg_rd(3'd0);
    check("R4 current mask", rd_new, 16'h003F);
    check("R4 legacy mask", rd_old, 16'h001F);
  endtask

  task automatic t_irq();
    do_reset();
    reg_wr(3'd0, 16'h0004);
    pulse(16'h0001, 16'h0);
    @(negedge clk);
    check("R1 unmasked no irq", {15'b0, n_irq}, 16'h0);
    pulse(16'h0004, 16'h0);
    check("R1 irq one cycle late", {15'b0, n_irq}, 16'h0);
    @(negedge clk);
    check("R1 irq current", {15'b0, n_irq}, 16'h1);
    check("R1 irq legacy", {15'b0, o_irq}, 16'h1);
    pulse(16'h0, 16'h0004);
    @(negedge clk);
    check("R1 irq drop", {15'b0, n_irq}, 16'h0);
  endtask

  task automatic t_dma();
    do_reset();
    pulse(16'h0018, 16'h0);
    @(negedge clk);
    check("R2 disabled", {14'b0, n_rx, n_tx}, 16'h0);
    reg_wr(3'd0, 16'h0018);
    @(negedge clk);
    check("R1 rdy irq", {15'b0, n_irq}, 16'h1);
    reg_wr(3'd3, 16'hFFFF);
    reg_rd(3'd3);
    check("R3 cfg keep", rd_new, 16'h8080);
    reg_rd(3'd0);
    check("R3 ie dropped", rd_new, 16'h0000);
    check("R2 both req", {14'b0, n_rx, n_tx}, 16'h3);
    check("R3 irq gone", {15'b0, n_irq}, 16'h0);
    pulse(16'h0, 16'h0008);
    @(negedge clk);
    check("R2 rx follows", {14'b0, n_rx, n_tx}, 16'h1);
    reg_wr(3'd3, 16'h0080);
    @(negedge clk);
    check("R2 rx dma only tx", {14'b0, o_rx, o_tx}, 16'h1);
  endtask

  task automatic t_w1c();
    do_reset();
    pulse(16'h023F, 16'h0);
    reg_wr(3'd1, 16'hFFFF);
    reg_rd(3'd1);
    check("R6 w1c selected bits", rd_new, 16'h0218);
    check("R7 legacy status ro", rd_old, 16'h023F);
  endtask

  task automatic t_vector();
    do_reset();
    reg_wr(3'd0, 16'h001F);
    pulse(16'h0014, 16'h0);
    reg_rd(3'd2);
    check("R5 vector first", rd_old, 16'd3);
    check("R7 current vector zero", rd_new, 16'd0);
    reg_rd(3'd1);
    check("R5 bit cleared", rd_old, 16'h0010);
    check("R7 current untouched", rd_new, 16'h0014);
    reg_rd(3'd2);
    check("R5 vector second", rd_old, 16'd5);
    reg_rd(3'd2);
    check("R5 vector none", rd_old, 16'd0);
    pulse(16'h0020, 16'h0);
    reg_rd(3'd2);
    check("R5 masked out", rd_old, 16'd0);
  endtask

  task automatic t_busy();
    do_reset();
    pulse(16'h1000, 16'h0);
    reg_rd(3'd1);
    check("R8 not stored", rd_new, 16'h0000);
    bus_busy = 1'b1;
    reg_rd(3'd1);
    check("R8 busy shown", rd_new, 16'h1000);
    check("R8 busy legacy", rd_old, 16'h1000);
    bus_busy = 1'b0;
  endtask

  task automatic t_force();
    do_reset();
    reg_wr(3'd4, 16'h0800);
    reg_rd(3'd1);
    check("R9 forced", rd_new, 16'h003F);
    check("R9 legacy none", rd_old, 16'h0000);
  endtask

  task automatic t_prio();
    do_reset();
    pulse(16'h0042, 16'h0042);
    reg_rd(3'd1);
    check("R10 set wins", rd_new, 16'h0042);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_mask_width();
    t_irq();
    t_dma();
    t_w1c();
    t_vector();
    t_busy();
    t_force();
    t_prio();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule